// File: doc/BRIEF.md
# Timer-Paced Converter Sampling Front-End

This block sits on the host side of an 8-bit successive-approximation converter. The converter has an active-low select, an active-low read and an active-low busy line. The block paces conversions with a programmable period timer. That timer runs on the same clock that drives the converter. On each timer tick the block performs one read access. In this access mode, a read returns the result of the previous conversion and starts the next one. Accesses start at fixed tick intervals and the converter holds its input a fixed number of clocks after each access begins, so sample instants are evenly spaced.

Each fetched result is written into a small synchronous FIFO. A processor drains the FIFO at its own pace through a valid/ready port. Back-pressure works as follows. `smp_data` is offered whenever `smp_valid` is high. One word leaves the FIFO on every clock edge where `smp_valid` and `smp_ready` are both high. While `smp_ready` stays low, the offered word does not change. If the FIFO is full when a new result arrives, the new result is lost and a sticky flag records the loss. Back-pressure never stalls the converter pacing.

The block never starts an access while the converter reports busy. A tick that arrives during a conversion is held back until busy clears, and a sticky overrun flag records the event. The first result fetched after enable is left over from before the run, so it is discarded.

Top module: `adc_pace_front`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_rd_n` are high, `smp_valid` is low, and `overrun` and `overflow` are low.
- R2: While enabled and the converter is idle at each tick, successive falling edges of `adc_cs_n` are exactly max(`period`, 20) clocks apart.
- R3: `adc_cs_n` and `adc_rd_n` always carry the same value. Each access holds them low for exactly ACC_LEN (default 2) clocks. The data word is captured on the last of those clocks.
- R4: An access never begins while `adc_busy_n` is low. A tick that arrives while the converter is busy, or while an earlier tick is still waiting, delays the access until `adc_busy_n` is high and sets `overrun`, which stays high until cleared.
- R5: The word fetched by the first access after `enable` rises is discarded. Every later fetched word enters the FIFO in fetch order, so N accesses yield N-1 words.
- R6: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data` holds its value. One word is removed per clock where both are high.
- R7: A fetched word that finds the FIFO full (FIFO_DEPTH words, default 4) is dropped, and `overflow` is set. `overflow` stays high until cleared.
- R8: A one-clock pulse on `clr_flags` returns both `overrun` and `overflow` to low when no new event occurs in the same clock.
- R9: While `enable` is low, no access is started and the tick counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the converter |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the pacing timer and access engine |
| period | input | PERIOD_W | Sample spacing in clocks; values below 20 act as 20 |
| clr_flags | input | 1 | Clears the sticky overrun and overflow flags |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_rd_n | output | 1 | Converter read, active low |
| adc_busy_n | input | 1 | Converter busy, low during a conversion |
| adc_data | input | DATA_W | Converter data bus |
| smp_data | output | DATA_W | FIFO head word |
| smp_valid | output | 1 | FIFO holds at least one word |
| smp_ready | input | 1 | Consumer accepts the head word |
| overrun | output | 1 | Sticky: a tick was delayed by a busy converter |
| overflow | output | 1 | Sticky: a result was dropped on a full FIFO |

## Verification
The hardest case to reach is the deferred access. Period clamping normally keeps every tick clear of a running conversion. The behavioural converter in the bench therefore has an adjustable extra busy time, and the bench raises it so that busy outlasts the minimum period. Ticks then land on a busy converter. The bench checks that each access still starts only after busy returns high, that `overrun` latches, and that the scoreboard's fetch order stays intact. The bench reaches overflow by holding `smp_ready` low through several accesses, and it then counts exactly FIFO_DEPTH words when draining.

// File: rtl/adc_pace_pkg.sv
package adc_pace_pkg;
  parameter int unsigned APF_MIN_PERIOD = 20;

  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_LOW  = 1'b1
  } acc_state_e;
endpackage

// File: rtl/apf_timer.sv
module apf_timer #(
  parameter int unsigned PERIOD_W   = 16,
  parameter int unsigned MIN_PERIOD = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] eff;

  // clamp keeps spacing at least one full conversion
  assign eff  = (period < MIN_P) ? MIN_P : period;
  assign tick = en && (cnt >= eff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/apf_access.sv
module apf_access
  import adc_pace_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ACC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              busy_n,
  input  logic [DATA_W-1:0] adc_data,
  output logic              cs_n,
  output logic              rd_n,
  output logic              cap_vld,
  output logic [DATA_W-1:0] cap_data,
  output logic              overrun_set
);
  localparam int unsigned AW = (ACC_LEN > 1) ? $clog2(ACC_LEN) : 1;
  localparam logic [AW-1:0] LAST = AW'(ACC_LEN - 1);

  acc_state_e  st;
  logic [AW-1:0] acnt;
  logic        pend;
  logic        stale;
  logic        start;

  assign start       = en && pend && busy_n && (st == ACC_IDLE);
  assign overrun_set = tick && (pend || !busy_n || (st != ACC_IDLE));
  assign rd_n        = cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ACC_IDLE;
      acnt     <= '0;
      pend     <= 1'b0;
      stale    <= 1'b1;
      cs_n     <= 1'b1;
      cap_vld  <= 1'b0;
      cap_data <= '0;
    end else begin
      cap_vld <= 1'b0;
      if (!en)        pend <= 1'b0;
      else if (tick)  pend <= 1'b1;
      else if (start) pend <= 1'b0;
      case (st)
        ACC_IDLE: begin
          if (start) begin
            st   <= ACC_LOW;
            cs_n <= 1'b0;
            acnt <= '0;
          end
        end
        ACC_LOW: begin
          if (acnt == LAST) begin
            st       <= ACC_IDLE;
            cs_n     <= 1'b1;
            cap_data <= adc_data;
            cap_vld  <= !stale;
            stale    <= 1'b0;
          end else begin
            acnt <= acnt + 1'b1;
          end
        end
        default: st <= ACC_IDLE;
      endcase
      if (!en) stale <= 1'b1;
    end
  end
endmodule

// File: rtl/apf_fifo.sv
module apf_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              do_push, do_pop;

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign do_pop    = out_valid && out_ready;
  assign do_push   = push && !full;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)                            mem[i] <= '0;
        else if (do_push && wp == PW'(i))      mem[i] <= push_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PMAX) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PMAX) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/adc_pace_front.sv
module adc_pace_front
  import adc_pace_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PERIOD_W   = 16,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned ACC_LEN    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  input  logic                clr_flags,
  output logic                adc_cs_n,
  output logic                adc_rd_n,
  input  logic                adc_busy_n,
  input  logic [DATA_W-1:0]   adc_data,
  output logic [DATA_W-1:0]   smp_data,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic                overrun,
  output logic                overflow
);
  logic              tick;
  logic              cap_vld;
  logic [DATA_W-1:0] cap_data;
  logic              ovr_set;
  logic              fifo_full;

  apf_timer #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(APF_MIN_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(enable), .period(period), .tick(tick)
  );

  apf_access #(.DATA_W(DATA_W), .ACC_LEN(ACC_LEN)) u_access (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick),
    .busy_n(adc_busy_n), .adc_data(adc_data),
    .cs_n(adc_cs_n), .rd_n(adc_rd_n),
    .cap_vld(cap_vld), .cap_data(cap_data), .overrun_set(ovr_set)
  );

  apf_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(cap_vld), .push_data(cap_data),
    .full(fifo_full), .out_data(smp_data), .out_valid(smp_valid),
    .out_ready(smp_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (ovr_set)                 overrun  <= 1'b1;
      else if (clr_flags)          overrun  <= 1'b0;
      if (cap_vld && fifo_full)    overflow <= 1'b1;
      else if (clr_flags)          overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_pace_chk.sv
module adc_pace_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ACC_LEN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_flags,
  input logic              adc_cs_n,
  input logic              adc_rd_n,
  input logic              adc_busy_n,
  input logic [DATA_W-1:0] smp_data,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              overrun,
  input logic              overflow
);
  // R3
  cs_rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n == adc_rd_n);

  generate
    if (ACC_LEN > 1) begin : g_hold
      // R3
      acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |=> !adc_cs_n);
    end
  endgenerate

  // R4
  start_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(adc_busy_n));

  // R4
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr_flags |=> overrun);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr_flags |=> overflow);
endmodule

bind adc_pace_front adc_pace_chk #(.DATA_W(DATA_W), .ACC_LEN(ACC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags),
  .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_busy_n(adc_busy_n),
  .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .overrun(overrun), .overflow(overflow)
);

// File: tb/tb_adc_pace_front.sv
`timescale 1ns/1ps
module tb_adc_pace_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] period = 16'd25;
  logic        clr_flags = 1'b0;
  logic        adc_cs_n, adc_rd_n, adc_busy_n;
  logic [7:0]  adc_data;
  logic [7:0]  smp_data;
  logic        smp_valid;
  logic        smp_ready = 1'b1;
  logic        overrun, overflow;

  always #10 clk = ~clk;

  adc_pace_front dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
    .clr_flags(clr_flags), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
    .adc_busy_n(adc_busy_n), .adc_data(adc_data), .smp_data(smp_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .overrun(overrun),
    .overflow(overflow)
  );

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural converter
  logic [7:0] m_ain = 8'h11;
  logic [7:0] m_held = 8'h00;
  logic [7:0] m_result = 8'hA5;
  int         m_bcnt = 0;
  logic       m_prev_cs = 1'b1;
  bit         m_first = 1'b1;
  int         stretch = 0;
  logic [7:0] expq[$];

  assign adc_busy_n = (m_bcnt == 0);
  assign adc_data   = m_result;

  always @(posedge clk) begin
    cyc++;
    m_prev_cs <= adc_cs_n;
    if (m_prev_cs && !adc_cs_n) begin
      // driver: the word this access fetches is the previous conversion
      if (!m_first) expq.push_back(m_result);
      m_first = 1'b0;
      m_held <= m_ain;
      m_ain  <= m_ain * 8'd5 + 8'd3;
      m_bcnt <= 17 + stretch;
    end else if (m_bcnt != 0) begin
      m_bcnt <= m_bcnt - 1;
      if (m_bcnt == 1) m_result <= m_held;
    end
  end

  // monitor
  bit   sb_on = 1'b1;
  int   gap_exp = 0;
  int   last_fall = -1;
  int   nfall = 0;
  int   npop = 0;
  int   low_w = 0;
  logic prev_cs = 1'b1;
  logic prev_busy = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !adc_cs_n) begin
        check(prev_busy == 1'b1, "R4 start while busy", int'(prev_busy), 1);
        if (gap_exp != 0 && last_fall >= 0)
          check(cyc - last_fall == gap_exp, "R2 access spacing", cyc - last_fall, gap_exp);
        last_fall = cyc;
        nfall++;
        low_w = 1;
      end else if (!adc_cs_n) begin
        low_w++;
      end
      if (!prev_cs && adc_cs_n)
        check(low_w == 2, "R3 access width", low_w, 2);
      if (smp_valid && smp_ready) begin
        npop++;
        if (sb_on) begin
          if (expq.size() == 0) check(1'b0, "R5 unexpected word", int'(smp_data), -1);
          else begin
            automatic logic [7:0] e = expq.pop_front();
            check(smp_data == e, "R5 word order", int'(smp_data), int'(e));
          end
        end
      end
    end
    prev_cs   = adc_cs_n;
    prev_busy = adc_busy_n;
  end

  task automatic start_run(input logic [15:0] p, input int gap);
    @(posedge clk); #2;
    period    = p;
    m_first   = 1'b1;
    last_fall = -1;
    gap_exp   = gap;
    nfall     = 0;
    npop      = 0;
    enable    = 1'b1;
  endtask

  task automatic stop_run();
    @(posedge adc_cs_n);
    @(posedge clk); #2;
    enable = 1'b0;
    repeat (40) @(posedge clk);
    #2;
  endtask

  task automatic wait_falls(input int n);
    while (nfall < n) @(posedge clk);
  endtask

  task automatic pulse_clr();
    @(posedge clk); #2 clr_flags = 1'b1;
    @(posedge clk); #2 clr_flags = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(adc_cs_n == 1'b1, "R1 cs_n", int'(adc_cs_n), 1);
    check(adc_rd_n == 1'b1, "R1 rd_n", int'(adc_rd_n), 1);
    check(smp_valid == 1'b0, "R1 valid", int'(smp_valid), 0);
    check(overrun == 1'b0 && overflow == 1'b0, "R1 flags", int'({overrun, overflow}), 0);
    #2 rst_n = 1'b1;

    // R2 R5: plain period
    start_run(16'd25, 25);
    wait_falls(10);
    stop_run();
    check(npop == nfall - 1, "R5 words per accesses", npop, nfall - 1);
    check(expq.size() == 0, "R5 queue drained", expq.size(), 0);
    check(overflow == 1'b0, "R7 no overflow while drained", int'(overflow), 0);
    check(overrun == 1'b0, "R4 no overrun at slow rate", int'(overrun), 0);

    // R2 clamp
    start_run(16'd5, 20);
    wait_falls(8);
    stop_run();
    check(npop == nfall - 1, "R2 R5 clamped run words", npop, nfall - 1);
    check(overrun == 1'b0, "R4 no overrun at minimum period", int'(overrun), 0);

    // R4 deferral with slow converter
    stretch = 10;
    start_run(16'd20, 0);
    wait_falls(5);
    stop_run();
    check(overrun == 1'b1, "R4 overrun latched", int'(overrun), 1);
    check(expq.size() == 0, "R4 order kept under deferral", expq.size(), 0);
    stretch = 0;
    pulse_clr();
    check(overrun == 1'b0, "R8 overrun cleared", int'(overrun), 0);

    // R7 R6 overflow
    sb_on = 1'b0;
    smp_ready = 1'b0;
    start_run(16'd20, 20);
    wait_falls(8);
    @(negedge clk);
    check(smp_valid == 1'b1, "R6 valid held", int'(smp_valid), 1);
    check(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
    begin
      automatic logic [7:0] d0 = smp_data;
      repeat (30) @(posedge clk);
      @(negedge clk);
      check(smp_data == d0, "R6 data stable under back-pressure", int'(smp_data), int'(d0));
    end
    stop_run();
    npop = 0;
    smp_ready = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(npop == 4, "R7 FIFO depth words kept", npop, 4);
    check(smp_valid == 1'b0, "R6 drained", int'(smp_valid), 0);
    check(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
    pulse_clr();
    check(overflow == 1'b0, "R8 overflow cleared", int'(overflow), 0);
    check(overrun == 1'b0, "R8 overrun stays clear", int'(overrun), 0);

    // R9 disabled: no accesses
    begin
      automatic int f0 = nfall;
      repeat (100) @(posedge clk);
      @(negedge clk);
      check(nfall == f0, "R9 no access while disabled", nfall - f0, 0);
      check(adc_cs_n == 1'b1, "R9 cs_n idle", int'(adc_cs_n), 1);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule